// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block gives three 8-bit general-purpose I/O ports (A, B and F) pin-level interrupt detection behind a byte-wide register bus. Each pin is set separately to level or edge detection and to either polarity. Each pin has an enable bit and an optional input filter that accepts a new level only after it has held for several sample ticks. An edge event latches into a per-pin pending bit. Software clears that bit by writing a one-hot or multi-bit mask to the port's acknowledge register. Level-mode pins report the live, qualified input and are not latched.

Ports A and B share one combined interrupt output. Each of the eight port F pins has its own interrupt line. Each port also has a data register and a direction register that drive the pads. Inputs pass through a two-flop synchronizer, and then the optional filter, before detection. Software emulates triggering on both edges by inverting a pin's polarity bit after each event; the block does not do this itself.

The register bus is a request stream that is never back-pressured: `bus_ready` is held high, and every cycle with `bus_valid` high completes one access. A read returns `rsp_data` with `rsp_valid` high for exactly one cycle, on the clock after the request. The response path has no ready input, so the requester must always take the response. Writes produce no response.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: All registers reset to 0. Read/write registers return the last value written. An address outside the map reads 0. Byte addresses (hex), per port A / B / F: enable 9C/B8/58, edge-select 90/AC/4C, polarity 94/B0/50, filter-enable A8/C4/64, status A0/BC/5C, acknowledge 98/B4/54, data 00/04/30, direction 10/14/34.
- R2: With edge-select bit 1 and enable bit 1, a pin's pending bit sets on a rising edge of the conditioned input when polarity is 1, and on a falling edge when polarity is 0. The opposite edge sets nothing.
- R3: With edge-select bit 0 and enable bit 1, the pin's status bit is 1 exactly while the conditioned input equals the polarity bit. Writes to the acknowledge register do not change it.
- R4: A pending bit stays set after the input returns, until a write to the acknowledge register with that bit 1. Mask bits written as 0 leave their pins pending.
- R5: A pin whose enable bit is 0 never shows status or raises an interrupt. Clearing the enable bit also discards the pin's pending bit, so re-enabling does not bring back an old event.
- R6: `irq_ab` is the OR of all port A and port B status bits. The status register of each port reads back its pins' status (bit n = pin n).
- R7: `irq_f[n]` equals the status of port F pin n, independently for each pin.
- R8: With the filter-enable bit 1, a new input level is accepted only after it has differed from the accepted level on DB_COUNT (default 4) consecutive sample ticks, one tick every TICK_DIV (default 4) clocks. A shorter glitch causes no event.
- R9: `pin_out` drives each port's data register and `pin_oe` its direction register (1 = output). A data read returns the data register bit for output pins and the synchronized pad input for input pins. Pin n of port A is bit n of the pin vectors, port B is bit 8+n and port F is bit 16+n.
- R10: Writes to a status register are ignored, and the acknowledge registers read 0.
- R11: `bus_ready` is always 1. A read request produces `rsp_valid` for one cycle on the next clock. Cycles without a read request produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Always high; request accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 8 | Read data |
| pin_in | input | 24 | Pad inputs, ports A, B, F from LSB |
| pin_out | output | 24 | Pad output values |
| pin_oe | output | 24 | Pad output enables |
| irq_ab | output | 1 | Shared interrupt of ports A and B |
| irq_f | output | 8 | Per-pin interrupts of port F |

## Verification
The embedded assertions watch on every cycle that a pending bit rises only from a qualified edge event, that it holds until an acknowledge or disable removes it, and that an acknowledge without a coinciding event clears it. They also check that the filtered level moves only on a sample tick, and that a read is answered on the following cycle and only then. Other behaviours can be shown only by the bench's scenarios: the choice of edge direction and level polarity, the OR into the shared line against the separate port F lines, the glitch rejection of the filter, and the register map with its read-back values.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT = 3;
  localparam int PW    = 8;

  typedef enum logic [3:0] {
    RK_NONE, RK_DATA, RK_DIR, RK_EDGE, RK_POL, RK_ACK, RK_EN, RK_DB, RK_STAT
  } reg_kind_e;

  typedef struct packed {
    logic [1:0] port;
    reg_kind_e  kind;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [7:0] a);
    reg_sel_t r;
    r = '{port: 2'd0, kind: RK_NONE};
    case (a)
      8'h00: r = '{port: 2'd0, kind: RK_DATA};
      8'h10: r = '{port: 2'd0, kind: RK_DIR};
      8'h90: r = '{port: 2'd0, kind: RK_EDGE};
      8'h94: r = '{port: 2'd0, kind: RK_POL};
      8'h98: r = '{port: 2'd0, kind: RK_ACK};
      8'h9C: r = '{port: 2'd0, kind: RK_EN};
      8'hA8: r = '{port: 2'd0, kind: RK_DB};
      8'hA0: r = '{port: 2'd0, kind: RK_STAT};
      8'h04: r = '{port: 2'd1, kind: RK_DATA};
      8'h14: r = '{port: 2'd1, kind: RK_DIR};
      8'hAC: r = '{port: 2'd1, kind: RK_EDGE};
      8'hB0: r = '{port: 2'd1, kind: RK_POL};
      8'hB4: r = '{port: 2'd1, kind: RK_ACK};
      8'hB8: r = '{port: 2'd1, kind: RK_EN};
      8'hC4: r = '{port: 2'd1, kind: RK_DB};
      8'hBC: r = '{port: 2'd1, kind: RK_STAT};
      8'h30: r = '{port: 2'd2, kind: RK_DATA};
      8'h34: r = '{port: 2'd2, kind: RK_DIR};
      8'h4C: r = '{port: 2'd2, kind: RK_EDGE};
      8'h50: r = '{port: 2'd2, kind: RK_POL};
      8'h54: r = '{port: 2'd2, kind: RK_ACK};
      8'h58: r = '{port: 2'd2, kind: RK_EN};
      8'h64: r = '{port: 2'd2, kind: RK_DB};
      8'h5C: r = '{port: 2'd2, kind: RK_STAT};
      default: r = '{port: 2'd0, kind: RK_NONE};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int W        = 8,
  parameter int DB_COUNT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] db_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(DB_COUNT + 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout[i] <= 1'b0;
        cnt     <= '0;
      end else if (!db_en[i]) begin
        dout[i] <= din[i];
        cnt     <= '0;
      end else if (tick) begin
        if (din[i] == dout[i]) begin
          cnt <= '0;
        end else if (cnt == CW'(DB_COUNT - 1)) begin
          dout[i] <= din[i];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    // filtered level only moves on a sample tick
    assert_db_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (db_en[i] && !tick) |=> (dout[i] == $past(dout[i])));
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int DB_COUNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sel_hit,
  input  logic          wr,
  input  reg_kind_e     kind,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rd_data,
  input  logic [PW-1:0] pad_in,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe,
  output logic [PW-1:0] status
);
  logic [PW-1:0] data_q, dir_q, edge_q, pol_q, en_q, db_q;
  logic [PW-1:0] s1, s2, filt, prev, pend;
  logic [PW-1:0] set_evt, ack, level_hit;
  logic          we;

  assign we = sel_hit && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; dir_q <= '0; edge_q <= '0;
      pol_q  <= '0; en_q  <= '0; db_q   <= '0;
    end else if (we) begin
      case (kind)
        RK_DATA: data_q <= wdata;
        RK_DIR:  dir_q  <= wdata;
        RK_EDGE: edge_q <= wdata;
        RK_POL:  pol_q  <= wdata;
        RK_EN:   en_q   <= wdata;
        RK_DB:   db_q   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0;
    end else begin
      s1 <= pad_in; s2 <= s1;
    end
  end

  gpio_irq_debounce #(.W(PW), .DB_COUNT(DB_COUNT)) u_db (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .db_en(db_q), .din(s2), .dout(filt)
  );

  assign set_evt   = en_q & edge_q & ((pol_q & filt & ~prev) | (~pol_q & ~filt & prev));
  assign ack       = (we && kind == RK_ACK) ? wdata : '0;
  assign level_hit = ~edge_q & ~(filt ^ pol_q);
  assign status    = en_q & (pend | level_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= filt;
      pend <= ((pend & ~ack) | set_evt) & en_q & edge_q;
    end
  end

  always_comb begin
    case (kind)
      RK_DATA: rd_data = (data_q & dir_q) | (s2 & ~dir_q);
      RK_DIR:  rd_data = dir_q;
      RK_EDGE: rd_data = edge_q;
      RK_POL:  rd_data = pol_q;
      RK_EN:   rd_data = en_q;
      RK_DB:   rd_data = db_q;
      RK_STAT: rd_data = status;
      default: rd_data = '0;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  for (genvar i = 0; i < PW; i++) begin : g_chk
    assert_pend_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[i] && !set_evt[i]) |=> !pend[i]);
    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !ack[i] && en_q[i] && edge_q[i]) |=> pend[i]);
    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set_evt[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int DB_COUNT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic                rsp_valid,
  output logic [7:0]          rsp_data,
  input  logic [NPORT*PW-1:0] pin_in,
  output logic [NPORT*PW-1:0] pin_out,
  output logic [NPORT*PW-1:0] pin_oe,
  output logic                irq_ab,
  output logic [PW-1:0]       irq_f
);
  localparam int TW = $clog2(TICK_DIV + 1);

  reg_sel_t      sel;
  logic [TW-1:0] tcnt;
  logic          tick;
  logic [PW-1:0] prd  [NPORT];
  logic [PW-1:0] stat [NPORT];
  logic [PW-1:0] rd_mux;

  assign bus_ready = 1'b1;
  assign sel       = decode_addr(bus_addr);
  assign tick      = (tcnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_irq_port #(.DB_COUNT(DB_COUNT)) u_port (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .sel_hit(bus_valid && sel.kind != RK_NONE && sel.port == 2'(p)),
      .wr(bus_write), .kind(sel.kind), .wdata(bus_wdata),
      .rd_data(prd[p]),
      .pad_in(pin_in[p*PW +: PW]),
      .pad_out(pin_out[p*PW +: PW]),
      .pad_oe(pin_oe[p*PW +: PW]),
      .status(stat[p])
    );
  end

  always_comb begin
    case (sel.port)
      2'd0:    rd_mux = prd[0];
      2'd1:    rd_mux = prd[1];
      2'd2:    rd_mux = prd[2];
      default: rd_mux = '0;
    endcase
    if (sel.kind == RK_NONE) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= bus_valid && !bus_write;
      rsp_data  <= (bus_valid && !bus_write) ? rd_mux : '0;
    end
  end

  assign irq_ab = |stat[0] | |stat[1];
  assign irq_f  = stat[2];

  assert_rsp_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);
  assert_rsp_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;
  logic        irq_ab;
  logic [7:0]  irq_f;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] mdl [3][5];

  always #2.5 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_ab(irq_ab), .irq_f(irq_f)
  );

  // kind: 0 edge, 1 polarity, 2 enable, 3 filter, 4 direction, 5 status, 6 ack, 7 data
  function automatic logic [7:0] addr_of(input int port, input int kind);
    logic [7:0] t [3][8];
    t[0] = '{8'h90, 8'h94, 8'h9C, 8'hA8, 8'h10, 8'hA0, 8'h98, 8'h00};
    t[1] = '{8'hAC, 8'hB0, 8'hB8, 8'hC4, 8'h14, 8'hBC, 8'hB4, 8'h04};
    t[2] = '{8'h4C, 8'h50, 8'h58, 8'h64, 8'h34, 8'h5C, 8'h54, 8'h30};
    return t[port][kind];
  endfunction

  function automatic bit is_mapped(input logic [7:0] a);
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 8; k++)
        if (addr_of(p, k) == a) return 1;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = rsp_data; v = rsp_valid;
    bus_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    void'($urandom(32'h5eed));
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 irq_ab reset", irq_ab, 0);
    chk("R1 irq_f reset", irq_f, 0);
    chk("R9 pin_oe reset", pin_oe, 0);
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 6; k++) begin
        rd(addr_of(p, k), d, v);
        chk("R1 reset read", d, 0);
      end
    chk("R11 bus_ready", bus_ready, 1);
    rd(8'h90, d, v);
    chk("R11 rsp_valid on read", v, 1);
    wait_cyc(1);
    chk("R11 no rsp when idle", rsp_valid, 0);

    // R9 data/direction
    wr(addr_of(0, 4), 8'hF0);
    wr(addr_of(0, 7), 8'hA5);
    pin_in[7:0] = 8'h0C;
    wait_cyc(3);
    chk("R9 pin_oe", pin_oe[7:0], 8'hF0);
    chk("R9 pin_out", pin_out[7:0], 8'hA5);
    rd(addr_of(0, 7), d, v);
    chk("R9 data read mix", d, 8'hAC);

    // R2 rising edge on A pin0
    wr(addr_of(0, 0), 8'h01);
    wr(addr_of(0, 1), 8'h01);
    wr(addr_of(0, 2), 8'h01);
    pin_in[0] = 1; wait_cyc(6);
    chk("R2 rising edge irq_ab", irq_ab, 1);
    rd(addr_of(0, 5), d, v);
    chk("R6 status A", d, 8'h01);
    pin_in[0] = 0; wait_cyc(6);
    chk("R4 pending holds", irq_ab, 1);
    wr(addr_of(0, 6), 8'h02);
    wait_cyc(1);
    chk("R4 zero mask bit no effect", irq_ab, 1);
    wr(addr_of(0, 6), 8'h01);
    wait_cyc(1);
    chk("R4 ack clears", irq_ab, 0);
    wr(addr_of(0, 5), 8'hFF);
    rd(addr_of(0, 5), d, v);
    chk("R10 status write ignored", d, 0);
    rd(addr_of(0, 6), d, v);
    chk("R10 ack reads 0", d, 0);

    // R2 falling edge on B pin3
    wr(addr_of(1, 0), 8'h08);
    wr(addr_of(1, 1), 8'h00);
    wr(addr_of(1, 2), 8'h08);
    pin_in[11] = 1; wait_cyc(6);
    chk("R2 opposite edge ignored", irq_ab, 0);
    pin_in[11] = 0; wait_cyc(6);
    chk("R2 falling edge irq_ab", irq_ab, 1);
    rd(addr_of(1, 5), d, v);
    chk("R6 status B", d, 8'h08);
    wr(addr_of(1, 6), 8'h08);
    wait_cyc(1);
    chk("R4 ack B", irq_ab, 0);

    // R3/R7 level mode on F
    wr(addr_of(2, 1), 8'h04);
    wr(addr_of(2, 2), 8'h06);
    wait_cyc(2);
    chk("R3 active-low level", irq_f, 8'h02);
    pin_in[18] = 1; wait_cyc(5);
    chk("R7 per-pin lines", irq_f, 8'h06);
    wr(addr_of(2, 6), 8'h06);
    wait_cyc(1);
    chk("R3 ack no effect on level", irq_f, 8'h06);
    pin_in[17] = 1; wait_cyc(5);
    chk("R3 level follows input", irq_f, 8'h04);
    chk("R6 F not on shared line", irq_ab, 0);
    pin_in[18:17] = 2'b00;

    // R5 enable gating
    wr(addr_of(0, 2), 8'h00);
    pin_in[0] = 1; wait_cyc(6);
    chk("R5 disabled no irq", irq_ab, 0);
    rd(addr_of(0, 5), d, v);
    chk("R5 disabled status", d, 0);
    pin_in[0] = 0; wait_cyc(6);
    wr(addr_of(0, 2), 8'h01);
    pin_in[0] = 1; wait_cyc(6);
    chk("R5 enabled irq", irq_ab, 1);
    wr(addr_of(0, 2), 8'h00);
    wait_cyc(1);
    chk("R5 disable masks", irq_ab, 0);
    wr(addr_of(0, 2), 8'h01);
    wait_cyc(2);
    chk("R5 pending discarded", irq_ab, 0);
    pin_in[0] = 0;

    // R8 filter on F pin5
    wr(addr_of(2, 2), 8'h00);
    wr(addr_of(2, 0), 8'h20);
    wr(addr_of(2, 1), 8'h20);
    wr(addr_of(2, 3), 8'h20);
    wr(addr_of(2, 2), 8'h20);
    wait_cyc(2);
    pin_in[21] = 1; wait_cyc(2);
    pin_in[21] = 0; wait_cyc(30);
    chk("R8 glitch rejected", irq_f, 0);
    pin_in[21] = 1; wait_cyc(3);
    chk("R8 not accepted early", irq_f, 0);
    wait_cyc(40);
    chk("R8 stable level accepted", irq_f, 8'h20);
    wr(addr_of(2, 6), 8'h20);
    pin_in[21] = 0;

    // R1 random read-back and unmapped reads
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 5; k++) begin
        wr(addr_of(p, k), 8'h00);
        mdl[p][k] = 8'h00;
      end
    for (int n = 0; n < 60; n++) begin
      int p, k;
      logic [7:0] val;
      p = int'($urandom_range(0, 2));
      k = int'($urandom_range(0, 4));
      val = 8'($urandom);
      wr(addr_of(p, k), val);
      mdl[p][k] = val;
      p = int'($urandom_range(0, 2));
      k = int'($urandom_range(0, 4));
      rd(addr_of(p, k), d, v);
      chk("R1 random read-back", d, mdl[p][k]);
    end
    for (int n = 0; n < 20; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if (!is_mapped(a)) begin
        rd(a, d, v);
        chk("R1 unmapped reads 0", d, 0);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule